// File: doc/BRIEF.md
# Three-Port Parallel I/O Peripheral

This block gives a small CPU three byte-wide parallel ports and one control word, all on a 2-bit address and an 8-bit data bus. Addresses 0, 1 and 2 reach ports A, B and C. Address 3 is a write-only control location. A write there with bit 7 high reprograms the port modes and directions. A write there with bit 7 low sets or clears one bit of the port C output latch.

In simple mode a port is a plain latch on output, and on input it passes the live pins through. In strobed mode a port becomes a handshaked input. An active-low strobe pin captures the port pins into a holding register and raises a buffer-full line. If the port's interrupt is enabled, the same capture also raises an interrupt line. Both lines clear when the CPU reads the port. In strobed mode three port C lines are taken over for this handshake. Port A uses the middle group, PC5 to PC3, and port B uses the low group, PC2 to PC0.

Every port has separate pin-input, pin-output and per-bit output-enable vectors. All registers change on the rising clock edge. Read data is combinational from the address and the read enable.

Top module: `pio_triport`

## Requirements
- R1: After reset, every output enable is 0 (all ports are inputs in simple mode), every output latch is 0, and both buffer-full flags and both interrupt flags are 0.
- R2: A control write with bit 7 set programs the ports. Bits 6:5 select the group A mode: 00 is simple, any other value is strobed. Bit 4 sets the port A direction, bit 3 the PC7..PC4 direction, bit 2 the group B mode (1 = strobed), bit 1 the port B direction and bit 0 the PC3..PC0 direction. A direction bit of 1 means input, so the matching output enables are 0. A direction bit of 0 means output, so the matching output enables are all 1.
- R3: A control write with bit 7 set clears the latches of ports A, B and C, both buffer-full flags and both interrupt flags, in the same edge.
- R4: In simple output mode, a write to a port address loads its latch, which then appears on the port's output pins. A read of that address returns the latch.
- R5: In simple input mode, a read of a port address returns the live input pins. Nothing is held.
- R6: A control write with bit 7 clear writes bit 0 into the port C latch bit indexed by bits 3:1. All other latch bits and the mode configuration stay unchanged.
- R7: With port A strobed, a low on PC4 at a clock edge captures the port A pins into the holding register and sets buffer full on PC5. A read of address 0 returns the held byte even after the pins change.
- R8: A read of port A in strobed mode clears PC5 and PC3 at the read edge. If PC4 is low at that same edge, the capture wins: the flags stay set and the new byte is held. The read returns the old byte.
- R9: Port A's interrupt line PC3 goes high on a capture only when port C latch bit 4 has been set with a single-bit write.
- R10: With port B strobed, PC2 is the active-low strobe, PC1 is buffer full and PC0 is the interrupt, enabled by port C latch bit 2. A read of address 1 returns the held byte and clears PC1 and PC0.
- R11: In strobed mode, the buffer-full and interrupt lines are driven (enable 1) and the strobe line is not driven. A read of address 2 returns the driven value of every driven bit and the pin value of every undriven bit, so handshake flags read live.
- R12: A strobed port is an input whatever its direction bit says, so its output enables are 0. Group A mode values 10 and 11 behave the same as 01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | 2 | Register select: 0 port A, 1 port B, 2 port C, 3 control |
| wrEn | input | 1 | Bus write strobe for one cycle |
| rdEn | input | 1 | Bus read strobe for one cycle |
| wrData | input | 8 | Bus write data |
| rdData | output | 8 | Bus read data, 0 when rdEn is low |
| paIn | input | 8 | Port A pin inputs |
| paOut | output | 8 | Port A output latch |
| paOe | output | 8 | Port A output enables |
| pbIn | input | 8 | Port B pin inputs |
| pbOut | output | 8 | Port B output latch |
| pbOe | output | 8 | Port B output enables |
| pcIn | input | 8 | Port C pin inputs, including the strobe lines |
| pcOut | output | 8 | Port C output values, with handshake lines substituted |
| pcOe | output | 8 | Port C output enables |

## Verification
A strobe capture and a CPU read of the same strobed port can land on one clock edge. One sets buffer full and the other clears it. The bench provokes this by driving the strobe low in the same cycle as a port A read, with new data on the pins. It judges the result on three points: the read returns the previously held byte, PC5 and PC3 stay high after the edge, and a second read returns the new byte and then clears both flags.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int DW = 8;
  localparam int NIB = DW / 2;
  localparam int IW = $clog2(DW);

  localparam logic [1:0] SEL_A = 2'd0;
  localparam logic [1:0] SEL_B = 2'd1;
  localparam logic [1:0] SEL_C = 2'd2;
  localparam logic [1:0] SEL_CTL = 2'd3;

  // Port C line positions used by the strobed handshakes
  localparam int A_STB = 4;
  localparam int A_IBF = 5;
  localparam int A_INT = 3;
  localparam int B_STB = 2;
  localparam int B_IBF = 1;
  localparam int B_INT = 0;

  typedef struct packed {
    logic strobedA;
    logic strobedB;
    logic inA;
    logic inB;
    logic inCU;
    logic inCL;
  } cfg_t;

  typedef struct packed {
    logic wrA;
    logic wrB;
    logic wrC;
    logic bitSr;
    logic [IW-1:0] bitIdx;
    logic bitVal;
    logic modeSet;
    logic rdA;
    logic rdB;
    logic rdOn;
    logic [1:0] sel;
    logic [DW-1:0] data;
  } strb_t;
endpackage

// File: rtl/pio_ctrl.sv
module pio_ctrl
  import pio_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic [1:0]    addr,
  input  logic          wrEn,
  input  logic          rdEn,
  input  logic [DW-1:0] wrData,
  output cfg_t          cfg,
  output strb_t         strb
);
  logic ctlHit;
  assign ctlHit = wrEn && (addr == SEL_CTL);

  always_comb begin
    strb = '0;
    strb.data = wrData;
    strb.sel = addr;
    strb.rdOn = rdEn;
    strb.wrA = wrEn && (addr == SEL_A);
    strb.wrB = wrEn && (addr == SEL_B);
    strb.wrC = wrEn && (addr == SEL_C);
    strb.modeSet = ctlHit && wrData[7];
    strb.bitSr = ctlHit && !wrData[7];
    strb.bitIdx = wrData[IW:1];
    strb.bitVal = wrData[0];
    strb.rdA = rdEn && (addr == SEL_A);
    strb.rdB = rdEn && (addr == SEL_B);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfg <= '{strobedA: 1'b0, strobedB: 1'b0, inA: 1'b1, inB: 1'b1, inCU: 1'b1, inCL: 1'b1};
    end else if (strb.modeSet) begin
      cfg.strobedA <= (wrData[6:5] != 2'b00);
      cfg.strobedB <= wrData[2];
      cfg.inA <= wrData[4];
      cfg.inB <= wrData[1];
      cfg.inCU <= wrData[3];
      cfg.inCL <= wrData[0];
    end
  end

  // R6
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.bitSr |=> $stable(cfg));
endmodule

// File: rtl/pio_hshk.sv
module pio_hshk #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          enable,
  input  logic          stbN,
  input  logic          inte,
  input  logic          rdReq,
  input  logic          clear,
  input  logic [DW-1:0] pins,
  output logic [DW-1:0] held,
  output logic          ibf,
  output logic          intr
);
  always_ff @(posedge clk) begin
    if (!rstN || clear) begin
      held <= '0;
      ibf  <= 1'b0;
      intr <= 1'b0;
    end else if (enable && !stbN) begin
      held <= pins;
      ibf  <= 1'b1;
      intr <= inte;
    end else if (enable && rdReq) begin
      ibf  <= 1'b0;
      intr <= 1'b0;
    end
  end

  // R9
  intr_needs_ibf_chk: assert property (@(posedge clk) disable iff (!rstN)
    intr |-> ibf);
  // R7
  ibf_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ibf) |-> $past(enable && !stbN));
  // R8
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enable && rdReq && stbN && !clear) |=> (!ibf && !intr));
endmodule

// File: rtl/pio_dp.sv
module pio_dp
  import pio_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  cfg_t          cfg,
  input  strb_t         strb,
  input  logic [DW-1:0] paIn,
  input  logic [DW-1:0] pbIn,
  input  logic [DW-1:0] pcIn,
  output logic [DW-1:0] rdData,
  output logic [DW-1:0] paOut,
  output logic [DW-1:0] paOe,
  output logic [DW-1:0] pbOut,
  output logic [DW-1:0] pbOe,
  output logic [DW-1:0] pcOut,
  output logic [DW-1:0] pcOe
);
  localparam int NCH = 2;

  logic [DW-1:0] outA, outB, outC;
  logic [NCH-1:0][DW-1:0] chPins, chHeld;
  logic [NCH-1:0] chEn, chStbN, chInte, chRd, chIbf, chIntr;
  logic [DW-1:0] pcRd, muxData;

  always_ff @(posedge clk) begin
    if (!rstN || strb.modeSet) begin
      outA <= '0;
      outB <= '0;
      outC <= '0;
    end else begin
      if (strb.wrA) outA <= strb.data;
      if (strb.wrB) outB <= strb.data;
      if (strb.wrC) outC <= strb.data;
      else if (strb.bitSr) outC[strb.bitIdx] <= strb.bitVal;
    end
  end

  assign chPins[0] = paIn;
  assign chPins[1] = pbIn;
  assign chEn   = {cfg.strobedB, cfg.strobedA};
  assign chStbN = {pcIn[B_STB], pcIn[A_STB]};
  assign chInte = {outC[B_STB], outC[A_STB]};
  assign chRd   = {strb.rdB, strb.rdA};

  for (genvar g = 0; g < NCH; g++) begin : gCh
    pio_hshk #(.DW(DW)) uHs (
      .clk   (clk),
      .rstN  (rstN),
      .enable(chEn[g]),
      .stbN  (chStbN[g]),
      .inte  (chInte[g]),
      .rdReq (chRd[g]),
      .clear (strb.modeSet),
      .pins  (chPins[g]),
      .held  (chHeld[g]),
      .ibf   (chIbf[g]),
      .intr  (chIntr[g])
    );
  end

  assign paOut = outA;
  assign pbOut = outB;
  assign paOe = {DW{~cfg.inA & ~cfg.strobedA}};
  assign pbOe = {DW{~cfg.inB & ~cfg.strobedB}};

  always_comb begin
    pcOut = outC;
    pcOe = {{NIB{~cfg.inCU}}, {NIB{~cfg.inCL}}};
    if (cfg.strobedA) begin
      pcOut[A_IBF] = chIbf[0];
      pcOut[A_INT] = chIntr[0];
      pcOut[A_STB] = 1'b0;
      pcOe[A_IBF] = 1'b1;
      pcOe[A_INT] = 1'b1;
      pcOe[A_STB] = 1'b0;
    end
    if (cfg.strobedB) begin
      pcOut[B_IBF] = chIbf[1];
      pcOut[B_INT] = chIntr[1];
      pcOut[B_STB] = 1'b0;
      pcOe[B_IBF] = 1'b1;
      pcOe[B_INT] = 1'b1;
      pcOe[B_STB] = 1'b0;
    end
  end

  for (genvar i = 0; i < DW; i++) begin : gCrd
    assign pcRd[i] = pcOe[i] ? pcOut[i] : pcIn[i];
  end

  always_comb begin
    case (strb.sel)
      SEL_A:   muxData = cfg.strobedA ? chHeld[0] : (cfg.inA ? paIn : outA);
      SEL_B:   muxData = cfg.strobedB ? chHeld[1] : (cfg.inB ? pbIn : outB);
      SEL_C:   muxData = pcRd;
      default: muxData = '0;
    endcase
    rdData = strb.rdOn ? muxData : '0;
  end

  // R3
  mode_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.modeSet |=> (paOut == '0 && pbOut == '0 && pcOut == '0));
  // R12
  strobed_in_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.strobedA |-> paOe == '0) and (cfg.strobedB |-> pbOe == '0));
  // R11
  hs_dir_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfg.strobedA |-> (pcOe[A_IBF] && pcOe[A_INT] && !pcOe[A_STB]));
endmodule

// File: rtl/pio_triport.sv
module pio_triport
  import pio_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic [1:0]    addr,
  input  logic          wrEn,
  input  logic          rdEn,
  input  logic [DW-1:0] wrData,
  output logic [DW-1:0] rdData,
  input  logic [DW-1:0] paIn,
  output logic [DW-1:0] paOut,
  output logic [DW-1:0] paOe,
  input  logic [DW-1:0] pbIn,
  output logic [DW-1:0] pbOut,
  output logic [DW-1:0] pbOe,
  input  logic [DW-1:0] pcIn,
  output logic [DW-1:0] pcOut,
  output logic [DW-1:0] pcOe
);
  cfg_t  cfg;
  strb_t strb;

  pio_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .cfg(cfg), .strb(strb)
  );

  pio_dp uDp (
    .clk(clk), .rstN(rstN), .cfg(cfg), .strb(strb),
    .paIn(paIn), .pbIn(pbIn), .pcIn(pcIn), .rdData(rdData),
    .paOut(paOut), .paOe(paOe), .pbOut(pbOut), .pbOe(pbOe),
    .pcOut(pcOut), .pcOe(pcOe)
  );
endmodule

// File: tb/tb_pio_triport.sv
module tb_pio_triport;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rstN = 1'b0;
  logic [1:0] addr = '0;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0] wrData = '0, rdData;
  logic [7:0] paIn = '0, pbIn = '0, pcIn = 8'hFF;
  logic [7:0] paOut, paOe, pbOut, pbOe, pcOut, pcOe;
  int checks = 0, fails = 0;
  bit done = 0;

  pio_triport dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wrData = d; wrEn = 1'b1;
    @(posedge clk); #1 wrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rdEn = 1'b1;
    #1 d = rdData;
    @(posedge clk); #1 rdEn = 1'b0;
  endtask

  task automatic pulse(input int idx);
    @(negedge clk); pcIn[idx] = 1'b0;
    @(posedge clk); #1 pcIn[idx] = 1'b1;
  endtask

  function automatic logic [23:0] expOe(input logic [6:0] m);
    logic sA, sB;
    logic [7:0] a, b, c;
    sA = (m[6:5] != 2'b00);
    sB = m[2];
    a = (!sA && !m[4]) ? 8'hFF : 8'h00;
    b = (!sB && !m[1]) ? 8'hFF : 8'h00;
    c = {{4{!m[3]}}, {4{!m[0]}}};
    if (sA) begin c[5] = 1'b1; c[3] = 1'b1; c[4] = 1'b0; end
    if (sB) begin c[1] = 1'b1; c[0] = 1'b1; c[2] = 1'b0; end
    return {a, b, c};
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, e;
    logic [23:0] oe;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    #1;
    // R1 reset state
    chk("R1 paOe", paOe, 8'h00);
    chk("R1 pbOe", pbOe, 8'h00);
    chk("R1 pcOe", pcOe, 8'h00);
    chk("R1 pcOut", pcOut, 8'h00);
    pcIn = 8'hA5; paIn = 8'h3E;
    rd(2, d); chk("R5 reset read C pins", d, 8'hA5);
    rd(0, d); chk("R5 reset read A pins", d, 8'h3E);
    pcIn = 8'hFF;

    // R2 R3 R12 sweep of every mode word
    for (int m = 0; m < 128; m++) begin
      wr(0, 8'hFF); wr(1, 8'hFF); wr(2, 8'hFF);
      wr(3, 8'h80 | 8'(m));
      oe = expOe(7'(m));
      chk("R2 R12 paOe", paOe, oe[23:16]);
      chk("R2 R12 pbOe", pbOe, oe[15:8]);
      chk("R2 R11 pcOe", pcOe, oe[7:0]);
      chk("R3 paOut", paOut, 8'h00);
      chk("R3 pbOut", pbOut, 8'h00);
      chk("R3 pcOut", pcOut, 8'h00);
    end

    // R4 simple output, all values
    wr(3, 8'h80);
    for (int v = 0; v < 256; v++) begin
      wr(0, 8'(v)); wr(1, ~8'(v));
      chk("R4 paOut", paOut, 8'(v));
      chk("R4 pbOut", pbOut, ~8'(v));
      rd(0, d); chk("R4 read A", d, 8'(v));
    end
    wr(2, 8'hC6); rd(2, d); chk("R4 read C", d, 8'hC6);

    // R5 simple input, pins pass through
    wr(3, 8'h9B);
    for (int v = 0; v < 256; v += 17) begin
      paIn = 8'(v); pbIn = 8'(v) ^ 8'h5A; pcIn = ~8'(v);
      rd(0, d); chk("R5 read A", d, 8'(v));
      rd(1, d); chk("R5 read B", d, 8'(v) ^ 8'h5A);
      rd(2, d); chk("R5 read C", d, ~8'(v));
    end
    pcIn = 8'hFF;

    // R6 single-bit set/reset sweep
    wr(3, 8'h80);
    for (int i = 0; i < 8; i++) begin
      for (int b = 0; b < 2; b++) begin
        wr(2, 8'h5A);
        wr(3, {4'b0000, 3'(i), 1'(b)});
        e = 8'h5A; e[i] = 1'(b);
        chk("R6 pcOut", pcOut, e);
        chk("R6 cfg kept paOe", paOe, 8'hFF);
      end
    end

    // R7 R8 R9 port A strobed, interrupt off
    wr(3, 8'hA0);
    paIn = 8'h3C;
    pulse(4);
    chk("R7 ibfA set", 8'(pcOut[5]), 8'h01);
    chk("R9 no intr without enable", 8'(pcOut[3]), 8'h00);
    paIn = 8'h00;
    rd(0, d); chk("R7 held A", d, 8'h3C);
    chk("R8 ibfA cleared", 8'(pcOut[5]), 8'h00);

    // R9 interrupt enabled via PC4 latch bit
    wr(3, 8'h09);
    paIn = 8'h77;
    pulse(4);
    chk("R9 intrA set", {pcOut[5], pcOut[3]}, 8'h03);
    rd(2, d); chk("R11 read C live flags", d, 8'h38);
    chk("R11 pcOe strobed A", pcOe, 8'hEF);

    // R8 collision: strobe and read in one edge
    paIn = 8'h99;
    @(negedge clk); addr = 2'd0; rdEn = 1'b1; pcIn[4] = 1'b0;
    #1 d = rdData;
    @(posedge clk); #1 rdEn = 1'b0; pcIn[4] = 1'b1;
    chk("R8 collision read old", d, 8'h77);
    chk("R8 collision flags kept", {pcOut[5], pcOut[3]}, 8'h03);
    rd(0, d); chk("R8 collision new data", d, 8'h99);
    chk("R8 flags cleared", {pcOut[5], pcOut[3]}, 8'h00);

    // R10 port B strobed
    wr(3, 8'h84);
    wr(3, 8'h05);
    pbIn = 8'hC3;
    pulse(2);
    chk("R10 ibfB intrB", {pcOut[1], pcOut[0]}, 8'h03);
    pbIn = 8'h11;
    rd(1, d); chk("R10 held B", d, 8'hC3);
    chk("R10 flags cleared", {pcOut[1], pcOut[0]}, 8'h00);

    // R12 group A mode 2 behaves as strobed input
    wr(3, 8'hD0);
    chk("R12 mode2 paOe", paOe, 8'h00);
    paIn = 8'h4D;
    pulse(4);
    chk("R12 mode2 ibf", 8'(pcOut[5]), 8'h01);
    rd(0, d); chk("R12 mode2 held", d, 8'h4D);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule